// File: doc/BRIEF.md
# Complementary Gate Driver with Dead Time and Latched Trip

This block sits between a PWM generator and a half-bridge. It turns one PWM source into two active-high gate signals. The high-side gate follows the source. The low-side gate follows the inverted source. Each gate turns on only after its own level has been held for a programmed number of clocks. The two gates turn off immediately. The gap this leaves between one switch turning off and the other turning on is the dead time. The turn-on delays of the two gates are set independently.

A protection latch overrides both gates. It is set by a hardware trip request or by a one-cycle software force strobe. Once set, it holds both gates low until a clear strobe arrives while the trip request is no longer asserted. The delay qualifiers keep tracking the source while the latch is set. On release, each gate therefore resumes exactly as its dead-time rule allows, and no early edge appears.

Top module: `gate_deadband_trip`

## Requirements
- R1: While `rst` is high, at every clock edge both gates become 0 and the trip latch is cleared, whatever the other inputs are.
- R2: `gate_a` is 1 in the cycle after edge k exactly when `pwm_in` was sampled 1 at edges k-`rise_dly` through k (that is, `rise_dly`+1 consecutive samples) and the latch is clear after edge k. It drops after the first edge that samples `pwm_in` at 0.
- R3: `gate_b` is 1 in the cycle after edge k exactly when `pwm_in` was sampled 0 at `fall_dly`+1 consecutive edges ending at k and the latch is clear after edge k. It drops after the first edge that samples `pwm_in` at 1.
- R4: A source pulse shorter than the programmed delay of a gate leaves that gate at 0 for the whole pulse; no partial pulse is emitted.
- R5: `gate_a` and `gate_b` are never 1 in the same cycle, including around trip entry and release.
- R6: An edge that samples `trip_req` or `trip_force` at 1 sets the latch, and both gates are 0 from that edge on.
- R7: Once set, the latch stays set, and both gates stay 0, through every edge that does not sample `trip_clear` at 1.
- R8: `trip_clear` has no effect at an edge where `trip_req` is also sampled 1; the gates stay 0.
- R9: An edge that samples `trip_clear` at 1 with both `trip_req` and `trip_force` at 0 releases the latch. From that edge on, the gates follow R2 and R3 using the source history accumulated during the trip.
- R10: With a delay of 0, the gate follows its level with exactly one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM source level |
| rise_dly | input | DLY_W | Turn-on delay of `gate_a`, in clocks |
| fall_dly | input | DLY_W | Turn-on delay of `gate_b`, in clocks |
| trip_req | input | 1 | Hardware trip request, level |
| trip_force | input | 1 | Software trip strobe |
| trip_clear | input | 1 | Software release strobe |
| gate_a | output | 1 | High-side gate, active high |
| gate_b | output | 1 | Low-side gate, active high |

## Verification
The bench sweeps every pairing of small turn-on delays against every short combination of high and low source widths, pulse widths of one clock included. A counter that is off by one would show up here as a gate that rises one clock early or late. An edge detector would show up as a gate that emits a sliver on a pulse shorter than its delay. Trip sequences apply a clear while the request is still held: a design that honours that clear would release the gates into a live fault. After the release, the source has been sitting in one level during the trip. A design that restarts its delay count on release, or that forgets the count, would then show a late edge or a premature one.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    // Pair of gate levels carried through the output register.
    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    // Channel selector used by the generate loop.
    typedef enum logic {
        CH_HIGH = 1'b0,
        CH_LOW  = 1'b1
    } chan_e;

    // Saturating increment of a run counter of width n.
    function automatic logic [15:0] sat_inc(input logic [15:0] v, input int n);
        logic [15:0] top;
        top = (16'd1 << n) - 16'd1;
        return (v >= top) ? top : v + 16'd1;
    endfunction

endpackage

// File: rtl/edge_qualifier.sv
module edge_qualifier #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level,
    input  logic [DLY_W-1:0] dly,
    output logic             qual_nxt
);
    import dbt_pkg::*;

    localparam int RUN_W = DLY_W + 1;

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nxt;
    logic [15:0]      inc_w;

    // Count consecutive samples of the level; a single miss restarts it.
    always_comb begin
        inc_w    = sat_inc(16'(run_q), RUN_W);
        run_nxt  = level ? inc_w[RUN_W-1:0] : '0;
        qual_nxt = level && (run_nxt > {1'b0, dly});
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= run_nxt;
    end
endmodule

// File: rtl/trip_latch.sv
module trip_latch (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic frc,
    input  logic clr,
    output logic trip_q,
    output logic trip_nxt
);
    // A set source wins over the clear strobe.
    always_comb begin
        if (req || frc) trip_nxt = 1'b1;
        else if (clr)   trip_nxt = 1'b0;
        else            trip_nxt = trip_q;
    end

    always_ff @(posedge clk) begin
        if (rst) trip_q <= 1'b0;
        else     trip_q <= trip_nxt;
    end
endmodule

// File: rtl/gate_deadband_trip.sv
module gate_deadband_trip #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    input  logic             trip_req,
    input  logic             trip_force,
    input  logic             trip_clear,
    output logic             gate_a,
    output logic             gate_b
);
    import dbt_pkg::*;

    localparam int NCH = 2;

    logic [NCH-1:0]   lvl;
    logic [DLY_W-1:0] dly [NCH];
    logic [NCH-1:0]   qual;
    logic             trip_q;
    logic             trip_nxt;
    gate_pair_t       gate_q;

    assign lvl[CH_HIGH] = pwm_in;
    assign lvl[CH_LOW]  = ~pwm_in;
    assign dly[CH_HIGH] = rise_dly;
    assign dly[CH_LOW]  = fall_dly;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        edge_qualifier #(.DLY_W(DLY_W)) u_q (
            .clk      (clk),
            .rst      (rst),
            .level    (lvl[c]),
            .dly      (dly[c]),
            .qual_nxt (qual[c])
        );
    end

    trip_latch u_trip (
        .clk      (clk),
        .rst      (rst),
        .req      (trip_req),
        .frc      (trip_force),
        .clr      (trip_clear),
        .trip_q   (trip_q),
        .trip_nxt (trip_nxt)
    );

    // Output register: trip overrides both gates on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
        end else begin
            gate_q.hi <= qual[CH_HIGH] && !trip_nxt;
            gate_q.lo <= qual[CH_LOW]  && !trip_nxt;
        end
    end

    assign gate_a = gate_q.hi;
    assign gate_b = gate_q.lo;
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker (
    input logic clk,
    input logic rst,
    input logic pwm_in,
    input logic trip_req,
    input logic trip_force,
    input logic trip_clear,
    input logic gate_a,
    input logic gate_b,
    input logic latched
);
    p_never_both_r5: assert property (@(posedge clk) disable iff (rst)
        !(gate_a && gate_b));

    p_a_needs_src_r2: assert property (@(posedge clk) disable iff (rst)
        gate_a |-> $past(pwm_in));

    p_b_needs_low_r3: assert property (@(posedge clk) disable iff (rst)
        gate_b |-> !$past(pwm_in));

    p_trip_forces_low_r6: assert property (@(posedge clk) disable iff (rst)
        (trip_req || trip_force) |=> (!gate_a && !gate_b));

    p_latch_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (latched && !trip_clear) |=> (!gate_a && !gate_b));

    p_clear_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (latched && trip_clear && trip_req) |=> (!gate_a && !gate_b));
endmodule

bind gate_deadband_trip dbt_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwm_in     (pwm_in),
    .trip_req   (trip_req),
    .trip_force (trip_force),
    .trip_clear (trip_clear),
    .gate_a     (gate_a),
    .gate_b     (gate_b),
    .latched    (trip_q)
);

// File: tb/sim_gate_deadband_trip.sv
module sim_gate_deadband_trip;
    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst, pwm, treq, tfrc, tclr;
    logic [W-1:0] rdly, fdly;
    logic         gate_a, gate_b;

    int checks = 0;
    int bad    = 0;
    int run_a  = 0;
    int run_b  = 0;
    int ph     = 0;
    bit m_trip = 0;
    bit m_a    = 0;
    bit m_b    = 0;

    gate_deadband_trip #(.DLY_W(W)) u0 (
        .clk(clk), .rst(rst), .pwm_in(pwm), .rise_dly(rdly), .fall_dly(fdly),
        .trip_req(treq), .trip_force(tfrc), .trip_clear(tclr),
        .gate_a(gate_a), .gate_b(gate_b)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model update at the edge, compare at the following falling edge.
    task automatic tick(string tag_a, string tag_b);
        @(posedge clk);
        if (rst) begin
            run_a = 0; run_b = 0; m_trip = 0; m_a = 0; m_b = 0;
        end else begin
            run_a = pwm ? run_a + 1 : 0;
            run_b = pwm ? 0 : run_b + 1;
            if (treq || tfrc) m_trip = 1;
            else if (tclr)    m_trip = 0;
            m_a = !m_trip && pwm  && (run_a > int'(rdly));
            m_b = !m_trip && !pwm && (run_b > int'(fdly));
        end
        @(negedge clk);
        chk(tag_a, gate_a, m_a);
        chk(tag_b, gate_b, m_b);
        chk("R5", gate_a && gate_b, 1'b0);
    endtask

    // Square wave, 5 clocks per level.
    task automatic wave(int n, string tag);
        for (int i = 0; i < n; i++) begin
            pwm = ((ph / 5) % 2) == 1;
            ph++;
            tick(tag, tag);
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        rst = 1; pwm = 1; treq = 1; tfrc = 1; tclr = 0; rdly = 0; fdly = 0;
        @(negedge clk);
        repeat (3) tick("R1", "R1");
        rst = 0; treq = 0; tfrc = 0; pwm = 0;

        // R10: zero delay, one clock latency
        for (int i = 0; i < 40; i++) begin
            pwm = ((i * 7) % 5) > 2;
            tick("R10", "R10");
        end

        // R2 / R3 sweep over delays and pulse widths
        for (int r = 0; r < 6; r++)
            for (int f = 0; f < 6; f++)
                for (int h = 1; h <= 8; h++)
                    for (int l = 1; l <= 8; l++) begin
                        rdly = W'(r); fdly = W'(f);
                        pwm = 1; repeat (h) tick("R2", "R3");
                        pwm = 0; repeat (l) tick("R2", "R3");
                    end

        // R4: pulses shorter than the delay
        rdly = 6; fdly = 6;
        pwm = 0; repeat (10) tick("R4", "R3");
        for (int w = 1; w <= 6; w++) begin
            pwm = 1; repeat (w) tick("R4", "R3");
            pwm = 0; repeat (10) tick("R2", "R3");
        end
        for (int w = 1; w <= 6; w++) begin
            pwm = 0; repeat (w) tick("R2", "R4");
            pwm = 1; repeat (10) tick("R2", "R3");
        end

        // Trip sequences
        rdly = 2; fdly = 2; ph = 0;
        wave(20, "R2");
        tfrc = 1; wave(1, "R6");
        tfrc = 0; wave(30, "R7");
        tclr = 1; wave(1, "R9");
        tclr = 0; wave(23, "R9");
        treq = 1; wave(5, "R6");
        tclr = 1; wave(10, "R8");
        treq = 0; tclr = 0; wave(12, "R7");
        tclr = 1; wave(1, "R9");
        tclr = 0; wave(30, "R9");
        treq = 1; tclr = 1; wave(3, "R8");
        treq = 0; wave(1, "R9");
        tclr = 0; wave(20, "R9");

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule